// File: doc/BRIEF.md
# Complement-Based Adder/Subtractor

This block adds or subtracts two WIDTH-bit operands with a single ripple adder. Subtraction adds the inverted subtrahend to the minuend. In two's-complement mode it also forces a carry-in of one. In one's-complement mode it feeds the carry out of the top bit back into the least significant position, which is the end-around carry. A second mode bit changes how the result is read. In signed mode the result is a complement-coded number with an overflow flag. In unsigned sign-magnitude mode a subtraction gives the magnitude of M−N together with a separate sign flag.

Every accepted operation is registered. Its outputs appear one clock after the input strobe. A two-state sequencer produces the output strobe:

- State `S_IDLE` means no result is presented.
- State `S_OUT` means a result is presented.
- The transition *accept* goes from `S_IDLE` to `S_OUT` when `in_valid` is high.
- The transition *stream* stays in `S_OUT` when another operation arrives.
- The transition *drain* goes from `S_OUT` to `S_IDLE` when `in_valid` is low.
- The transition *wait* stays in `S_IDLE` when `in_valid` is low.

Encodings:

- `op_sub`: 1 selects M−N and 0 selects M+N.
- `ones_mode`: 1 selects one's-complement arithmetic and 0 selects two's-complement arithmetic.
- `mag_mode`: 1 selects unsigned sign-magnitude output and 0 selects signed output.

Top module: `cmp_addsub`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock. While `rst` is high at a clock edge, `out_valid`, `result`, `sign_flag`, `ovf_flag` and `neg_zero` all become 0.
- R2: In signed two's-complement mode (`mag_mode`=0, `ones_mode`=0), `result` is (M+N) or (M−N) modulo 2^WIDTH, and the carry out of the top bit is dropped.
- R3: In signed one's-complement mode (`mag_mode`=0, `ones_mode`=1), `result` is M plus N, or M plus the bitwise inverse of N. When the sum exceeds 2^WIDTH−1, 2^WIDTH−1 is subtracted from it, so the carry re-enters at bit 0.
- R4: `neg_zero` is 1 in signed one's-complement mode exactly when `result` is all ones (for example M−M). It is always 0 in two's-complement mode, where M−M gives 0.
- R5: In signed mode, `ovf_flag` is 1 exactly when the true sum or difference lies outside the representable range. The range is −2^(WIDTH−1) to 2^(WIDTH−1)−1 in two's complement, and ±(2^(WIDTH−1)−1) in one's complement, where the top bit set means negative.
- R6: In unsigned sign-magnitude subtraction, when M≥N (two's mode) or M>N (one's mode), `result` is M−N and `sign_flag` is 0.
- R7: In unsigned sign-magnitude subtraction, when M<N, `result` is N−M and `sign_flag` is 1.
- R8: In unsigned sign-magnitude subtraction with M=N, one's mode gives `result`=0, `sign_flag`=1 and `neg_zero`=1. Two's mode gives `result`=0, `sign_flag`=0 and `neg_zero`=0.
- R9: In unsigned sign-magnitude mode, `ovf_flag` is always 0. Addition gives (M+N) modulo 2^WIDTH with `sign_flag` 0 and `neg_zero` 0.
- R10: In signed mode, `sign_flag` equals the top bit of `result`.
- R11: While `in_valid` is low, `result` and all flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and mode bits are valid |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| ones_mode | input | 1 | 1 = one's complement, 0 = two's complement |
| mag_mode | input | 1 | 1 = unsigned sign-magnitude, 0 = signed |
| opa | input | WIDTH | Operand M |
| opb | input | WIDTH | Operand N |
| out_valid | output | 1 | Result is valid |
| result | output | WIDTH | Sum, difference or magnitude |
| sign_flag | output | 1 | Result is negative |
| ovf_flag | output | 1 | Signed overflow |
| neg_zero | output | 1 | Result is minus zero |

## Verification
Small signed pairs are run in both complement modes. Their negative results separate the end-around correction from the discarded carry. Operands of equal value tell the minus-zero path apart from plain zero in both signed and unsigned modes. Values at the edges of the range (0x7F, 0x80, 0xFF) test the overflow rule, including a one's-complement case where the end-around carry ripples into the sign bit. Unsigned pairs with M above and below N, together with a pseudo-random sweep across all eight mode combinations, cover the re-complement to magnitude and the sign flag.

// File: rtl/cas_pkg.sv
package cas_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_OUT  = 1'b1
    } cas_state_e;
endpackage

// File: rtl/cas_operand_prep.sv
module cas_operand_prep #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opb,
    input  logic             op_sub,
    input  logic             ones_mode,
    output logic [WIDTH-1:0] b_eff,
    output logic             carry_in
);
    // Subtrahend is inverted; two's complement adds the extra one as carry-in
    assign b_eff    = op_sub ? ~opb : opb;
    assign carry_in = op_sub & ~ones_mode;
endmodule

// File: rtl/cas_ripple_adder.sv
module cas_ripple_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_top_in,
    output logic             c_out
);
    logic [WIDTH:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end

    assign c_top_in = carry[WIDTH-1];
    assign c_out    = carry[WIDTH];
endmodule

// File: rtl/cas_result_fix.sv
module cas_result_fix #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] raw,
    input  logic             c_top_in,
    input  logic             c_out,
    input  logic             op_sub,
    input  logic             ones_mode,
    input  logic             mag_mode,
    output logic [WIDTH-1:0] fixed,
    output logic             sign,
    output logic             ovf,
    output logic             nzero
);
    logic [WIDTH-1:0] pre;
    logic             inc;
    logic             inc_top;
    logic             inc_out;
    logic             negative_sm;
    logic [WIDTH-1:0] zero_vec;

    assign zero_vec    = '0;
    assign negative_sm = op_sub & ~c_out;

    // One incrementer serves both end-around carry and re-complementing
    always_comb begin
        if (!mag_mode) begin
            pre = raw;
            inc = ones_mode & c_out;
        end else if (!op_sub) begin
            pre = raw;
            inc = 1'b0;
        end else if (c_out) begin
            pre = raw;
            inc = ones_mode;
        end else begin
            pre = ~raw;
            inc = ~ones_mode;
        end
    end

    cas_ripple_adder #(.WIDTH(WIDTH)) u_inc (
        .a        (pre),
        .b        (zero_vec),
        .cin      (inc),
        .sum      (fixed),
        .c_top_in (inc_top),
        .c_out    (inc_out)
    );

    // Carry into sign includes any ripple from the correction pass
    assign ovf   = ~mag_mode & ((c_top_in | inc_top) ^ (c_out | inc_out));
    assign sign  = mag_mode ? negative_sm : fixed[WIDTH-1];
    assign nzero = mag_mode ? (negative_sm & ones_mode & (fixed == '0))
                            : (ones_mode & (&fixed));
endmodule

// File: rtl/cmp_addsub.sv
module cmp_addsub
    import cas_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             op_sub,
    input  logic             ones_mode,
    input  logic             mag_mode,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             sign_flag,
    output logic             ovf_flag,
    output logic             neg_zero
);
    cas_state_e       state_q, state_d;
    logic [WIDTH-1:0] b_eff;
    logic             cin;
    logic [WIDTH-1:0] raw;
    logic             c_top_in, c_out;
    logic [WIDTH-1:0] fixed;
    logic             sign_c, ovf_c, nz_c;

    cas_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .opb       (opb),
        .op_sub    (op_sub),
        .ones_mode (ones_mode),
        .b_eff     (b_eff),
        .carry_in  (cin)
    );

    cas_ripple_adder #(.WIDTH(WIDTH)) u_add (
        .a        (opa),
        .b        (b_eff),
        .cin      (cin),
        .sum      (raw),
        .c_top_in (c_top_in),
        .c_out    (c_out)
    );

    cas_result_fix #(.WIDTH(WIDTH)) u_fix (
        .raw       (raw),
        .c_top_in  (c_top_in),
        .c_out     (c_out),
        .op_sub    (op_sub),
        .ones_mode (ones_mode),
        .mag_mode  (mag_mode),
        .fixed     (fixed),
        .sign      (sign_c),
        .ovf       (ovf_c),
        .nzero     (nz_c)
    );

    // Next-state: accept / stream on in_valid, drain / wait otherwise
    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = in_valid ? S_OUT : S_IDLE;
            S_OUT:   state_d = in_valid ? S_OUT : S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    assign out_valid = (state_q == S_OUT);

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            sign_flag <= 1'b0;
            ovf_flag  <= 1'b0;
            neg_zero  <= 1'b0;
        end else if (in_valid) begin
            result    <= fixed;
            sign_flag <= sign_c;
            ovf_flag  <= ovf_c;
            neg_zero  <= nz_c;
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mag_mode) |=> !ovf_flag);
    // R9
    unsigned_add_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mag_mode && !op_sub) |=> (!sign_flag && !neg_zero));
    // R4
    twos_no_nz_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ones_mode) |=> !neg_zero);
    // R10
    signed_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mag_mode) |=> (sign_flag == result[WIDTH-1]));
    // R11
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(sign_flag) && $stable(neg_zero)));
endmodule

// File: tb/test_cmp_addsub.sv
module test_cmp_addsub;
    localparam int W    = 8;
    localparam int MASK = (1 << W) - 1;
    localparam int HALF = 1 << (W - 1);

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid, op_sub, ones_mode, mag_mode;
    logic [W-1:0] opa, opb;
    logic         out_valid, sign_flag, ovf_flag, neg_zero;
    logic [W-1:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    cmp_addsub #(.WIDTH(W)) i_cmp_addsub (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
        .ones_mode(ones_mode), .mag_mode(mag_mode), .opa(opa), .opb(opb),
        .out_valid(out_valid), .result(result), .sign_flag(sign_flag),
        .ovf_flag(ovf_flag), .neg_zero(neg_zero)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    function automatic int val1(input int x);
        return (x >= HALF) ? -((~x) & MASK) : x;
    endfunction

    function automatic int val2(input int x);
        return (x >= HALF) ? x - (1 << W) : x;
    endfunction

    function automatic void model(input int a, input int b, input bit sub, input bit ones,
                                  input bit mag, output int r, output bit s, output bit o,
                                  output bit z);
        int t, bb, sm;
        r = 0; s = 0; o = 0; z = 0;
        if (!mag) begin
            if (!ones) begin
                r = (sub ? a - b : a + b) & MASK;
                t = sub ? val2(a) - val2(b) : val2(a) + val2(b);
                o = (t > HALF - 1) || (t < -HALF);
            end else begin
                bb = sub ? ((~b) & MASK) : b;
                sm = a + bb;
                if (sm > MASK) sm = sm - MASK;
                r = sm;
                t = sub ? val1(a) - val1(b) : val1(a) + val1(b);
                o = (t > HALF - 1) || (t < -(HALF - 1));
                z = (r == MASK);
            end
            s = (r >= HALF);
        end else if (!sub) begin
            r = (a + b) & MASK;
        end else if (a > b || (a == b && !ones)) begin
            r = a - b;
        end else if (a == b) begin
            r = 0; s = 1; z = 1;
        end else begin
            r = b - a; s = 1;
        end
    endfunction

    task automatic run_op(input string req, input int a, input int b, input bit sub,
                          input bit ones, input bit mag);
        int r; bit s, o, z;
        model(a, b, sub, ones, mag, r, s, o, z);
        @(negedge clk);
        opa = a[W-1:0]; opb = b[W-1:0];
        op_sub = sub; ones_mode = ones; mag_mode = mag; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", "out_valid", int'(out_valid), 1);
        check(req, "result", int'(result), r);
        check(req, "sign_flag", int'(sign_flag), int'(s));
        check(req, "ovf_flag", int'(ovf_flag), int'(o));
        check(req, "neg_zero", int'(neg_zero), int'(z));
    endtask

    task automatic t_reset();
        run_op("R2", 9, 3, 1'b0, 1'b0, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1", "reset out_valid", int'(out_valid), 0);
        check("R1", "reset result", int'(result), 0);
        check("R1", "reset flags", int'({sign_flag, ovf_flag, neg_zero}), 0);
    endtask

    task automatic t_twos_signed();
        run_op("R2", 5, 2, 1'b0, 1'b0, 1'b0);
        run_op("R2", 5, 2, 1'b1, 1'b0, 1'b0);
        run_op("R2", 2, 5, 1'b1, 1'b0, 1'b0);
        run_op("R2", 8'hFB, 8'hFE, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_ones_signed();
        run_op("R3", 8'hFA, 8'hFD, 1'b0, 1'b1, 1'b0);
        run_op("R3", 5, 2, 1'b1, 1'b1, 1'b0);
        run_op("R3", 2, 5, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_negzero();
        run_op("R4", 8'h37, 8'h37, 1'b1, 1'b1, 1'b0);
        check("R4", "minus zero pattern", int'(result), MASK);
        run_op("R4", 8'h37, 8'h37, 1'b1, 1'b0, 1'b0);
        check("R4", "two's plain zero", int'(neg_zero), 0);
    endtask

    task automatic t_overflow();
        run_op("R5", 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0);
        run_op("R5", 8'h80, 8'h01, 1'b1, 1'b0, 1'b0);
        run_op("R5", 8'h80, 8'h80, 1'b0, 1'b0, 1'b0);
        run_op("R5", 8'h7F, 8'h01, 1'b0, 1'b1, 1'b0);
        run_op("R5", 8'h80, 8'hFF, 1'b0, 1'b1, 1'b0);
        run_op("R5", 8'h80, 8'h01, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_unsigned();
        run_op("R6", 200, 50, 1'b1, 1'b0, 1'b1);
        run_op("R6", 200, 50, 1'b1, 1'b1, 1'b1);
        run_op("R7", 50, 200, 1'b1, 1'b0, 1'b1);
        run_op("R7", 50, 200, 1'b1, 1'b1, 1'b1);
        run_op("R8", 77, 77, 1'b1, 1'b1, 1'b1);
        run_op("R8", 77, 77, 1'b1, 1'b0, 1'b1);
        run_op("R9", 200, 100, 1'b0, 1'b1, 1'b1);
        run_op("R9", 8'h7F, 8'h01, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_hold();
        run_op("R10", 8'h90, 8'h05, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        opa = 8'h01; opb = 8'h01; op_sub = 1'b1; ones_mode = 1'b1; mag_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R11", "held result", int'(result), 8'h8B);
        check("R11", "held neg_zero", int'(neg_zero), 0);
        check("R1", "out_valid low", int'(out_valid), 0);
    endtask

    task automatic t_sweep();
        int seed = 32'h1F3A;
        for (int i = 0; i < 40; i++) begin
            for (int m = 0; m < 8; m++) begin
                int a, b;
                seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
                a = (seed >> 8) & MASK;
                b = (seed >> 17) & MASK;
                run_op(m[2] ? "R6" : (m[1] ? "R3" : "R2"), a, b, m[0], m[1], m[2]);
            end
        end
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_sub = 1'b0; ones_mode = 1'b0; mag_mode = 1'b0;
        opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        check("R1", "initial out_valid", int'(out_valid), 0);
        check("R1", "initial result", int'(result), 0);
        rst = 1'b0;
        t_reset();
        t_twos_signed();
        t_ones_signed();
        t_negzero();
        t_overflow();
        t_unsigned();
        t_hold();
        t_sweep();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule